// File: doc/BRIEF.md
# Per-Line Black-Level Corrector

This block sits behind the digitiser of a three-channel linear image sensor. All three colour channels arrive together, one sample per channel per clock, with tags from the timing generator that mark the shielded (dark) part of each line, the active part and the start of a line. For each channel, the block averages the shielded samples at the head of the line and takes that average as the line's black level. It then subtracts the black level from every active sample of the same line as the samples stream through. The output is the corrected words and a valid strobe.

The average needs no divider. The block adds up a fixed number of shielded samples, a power of two, and shifts the sum right. A line whose shielded run is too short leaves the stored black level untouched, and the block raises an error flag for that line. Blank and test samples that carry neither tag are dropped.

Top module: `black_level_corrector`

## Requirements
- R1: While reset is applied and after it is released, `out_valid` and `short_err` are 0 until an active sample arrives.
- R2: The black level of a channel is the sum of the first DARK_N (16) samples tagged `dark_en` after `line_start`, shifted right by log2(DARK_N) bits (floor).
- R3: A sample tagged `act_en` in cycle t gives `out_valid`=1 and `pix_out` = sample minus that channel's black level in cycle t+1.
- R4: If the black level exceeds the active sample, the corrected word is 0.
- R5: Each channel c uses bits [c*PIX_W +: PIX_W] of `pix_in` and `pix_out`. Each channel keeps its own sum and black level.
- R6: A cycle with neither `dark_en` nor `act_en` adds nothing to the average and drives `out_valid` low in the next cycle. `pix_out` keeps its value.
- R7: Shielded samples after the DARK_N-th sample of a line are ignored.
- R8: If a line reaches its first active sample with fewer than DARK_N shielded samples, the previous black level stays in use. `short_err` goes to 1 in the next cycle and stays at 1 until the cycle after the next `line_start`.
- R9: `line_start` restarts the shielded-sample count and the sum. A `dark_en` sample in the same cycle counts as the first sample of the new line.
- R10: After reset, the black level of every channel is 0 until a complete shielded run has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| dark_en | input | 1 | Current samples are shielded reference samples |
| act_en | input | 1 | Current samples are active image samples |
| pix_in | input | NCH*PIX_W | Input samples, channel c at [c*PIX_W +: PIX_W] |
| pix_out | output | NCH*PIX_W | Corrected samples, same channel layout |
| out_valid | output | 1 | `pix_out` holds a corrected active sample |
| short_err | output | 1 | The current line's shielded run was too short |

## Verification
Every result of the block appears exactly one cycle after the input that causes it. A corrected word and its valid strobe follow their active sample by one cycle. The error flag follows the first active sample of a short line by one cycle, and clears one cycle after `line_start`. A new black level takes effect from the cycle after the DARK_N-th shielded sample. The bench drives inputs on the falling edge and checks outputs on the next falling edge, so each check sees the registers loaded by the single rising edge in between. The expected black levels come from a sum in the bench over the same shielded values it drove.

// File: rtl/blc_pkg.sv
package blc_pkg;
  // Default geometry of the corrector
  localparam int unsigned DEF_NCH    = 3;
  localparam int unsigned DEF_PIX_W  = 12;
  localparam int unsigned DEF_DARK_N = 16;
endpackage

// File: rtl/blc_line_ctl.sv
// Line sequencing: counts shielded samples, issues accumulate and commit
// strobes, tracks the short-run error.
module blc_line_ctl #(
  parameter int unsigned DARK_N = blc_pkg::DEF_DARK_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic dark_en,
  input  logic act_en,
  output logic acc_clr,
  output logic acc_en,
  output logic commit,
  output logic short_err
);
  localparam int unsigned CNT_W = $clog2(DARK_N + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DARK_N);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DARK_N - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
  logic             err_q, err_d;

  always_comb begin
    cnt_base = line_start ? '0 : cnt_q;
    acc_clr  = line_start;
    acc_en   = dark_en && (cnt_base < FULL);
    commit   = acc_en && (cnt_base == LAST);
    cnt_d    = acc_en ? cnt_base + 1'b1 : cnt_base;
    err_d    = (line_start ? 1'b0 : err_q) | (act_en && (cnt_base != FULL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign short_err = err_q;
endmodule

// File: rtl/blc_dark_avg.sv
// One channel: sums shielded samples and latches the average on commit.
module blc_dark_avg #(
  parameter int unsigned PIX_W  = blc_pkg::DEF_PIX_W,
  parameter int unsigned DARK_N = blc_pkg::DEF_DARK_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_clr,
  input  logic             acc_en,
  input  logic             commit,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] black
);
  localparam int unsigned SHIFT = $clog2(DARK_N);
  localparam int unsigned ACC_W = PIX_W + SHIFT;

  logic [ACC_W-1:0] acc_q, acc_d, acc_base, acc_sum;
  logic [PIX_W-1:0] blk_q, blk_d;

  always_comb begin
    acc_base = acc_clr ? '0 : acc_q;
    acc_sum  = acc_base + {{SHIFT{1'b0}}, pix};
    acc_d    = acc_en ? acc_sum : acc_base;
    blk_d    = commit ? acc_sum[ACC_W-1:SHIFT] : blk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      blk_q <= '0;
    end else begin
      acc_q <= acc_d;
      blk_q <= blk_d;
    end
  end

  assign black = blk_q;
endmodule

// File: rtl/blc_sub_clamp.sv
// One channel: subtracts the black level with a floor at zero.
module blc_sub_clamp #(
  parameter int unsigned PIX_W = blc_pkg::DEF_PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] black,
  output logic [PIX_W-1:0] corr
);
  logic [PIX_W-1:0] corr_q, corr_d;

  always_comb begin
    corr_d = corr_q;
    if (en) corr_d = (pix >= black) ? (pix - black) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) corr_q <= '0;
    else        corr_q <= corr_d;
  end

  assign corr = corr_q;
endmodule

// File: rtl/black_level_corrector.sv
module black_level_corrector #(
  parameter int unsigned NCH    = blc_pkg::DEF_NCH,
  parameter int unsigned PIX_W  = blc_pkg::DEF_PIX_W,
  parameter int unsigned DARK_N = blc_pkg::DEF_DARK_N
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_start,
  input  logic                 dark_en,
  input  logic                 act_en,
  input  logic [NCH*PIX_W-1:0] pix_in,
  output logic [NCH*PIX_W-1:0] pix_out,
  output logic                 out_valid,
  output logic                 short_err
);
  localparam int unsigned BUS_W = NCH * PIX_W;

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             acc_clr, acc_en, commit;
  logic             vld_q, vld_d;
  logic [BUS_W-1:0] black_bus;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  blc_line_ctl #(.DARK_N(DARK_N)) u_ctl (
    .clk(clk), .rst_n(rst_n_s), .line_start(line_start), .dark_en(dark_en),
    .act_en(act_en), .acc_clr(acc_clr), .acc_en(acc_en), .commit(commit),
    .short_err(short_err)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    blc_dark_avg #(.PIX_W(PIX_W), .DARK_N(DARK_N)) u_avg (
      .clk(clk), .rst_n(rst_n_s), .acc_clr(acc_clr), .acc_en(acc_en),
      .commit(commit), .pix(pix_in[c*PIX_W +: PIX_W]),
      .black(black_bus[c*PIX_W +: PIX_W])
    );
    blc_sub_clamp #(.PIX_W(PIX_W)) u_sub (
      .clk(clk), .rst_n(rst_n_s), .en(act_en),
      .pix(pix_in[c*PIX_W +: PIX_W]), .black(black_bus[c*PIX_W +: PIX_W]),
      .corr(pix_out[c*PIX_W +: PIX_W])
    );
  end

  always_comb vld_d = act_en;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) vld_q <= 1'b0;
    else          vld_q <= vld_d;
  end
  assign out_valid = vld_q;
endmodule

// File: rtl/blc_chk.sv
module blc_chk #(
  parameter int unsigned NCH   = blc_pkg::DEF_NCH,
  parameter int unsigned PIX_W = blc_pkg::DEF_PIX_W
) (
  input logic                 clk,
  input logic                 rst_s,
  input logic                 line_start,
  input logic                 dark_en,
  input logic                 act_en,
  input logic [NCH*PIX_W-1:0] pix_in,
  input logic [NCH*PIX_W-1:0] pix_out,
  input logic                 out_valid,
  input logic                 short_err,
  input logic [NCH*PIX_W-1:0] black_bus
);
  AST_VALID_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_s)
    act_en |=> out_valid); // R3
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_s)
    (!act_en) |=> (!out_valid && $stable(pix_out))); // R6
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_s)
    (line_start && !act_en) |=> !short_err); // R8
  AST_ERR_FROM_ACT: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(short_err) |-> $past(act_en)); // R8
  AST_BLACK_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (!dark_en) |=> $stable(black_bus)); // R9

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    AST_NEVER_ABOVE_IN: assert property (@(posedge clk) disable iff (!rst_s)
      act_en |=> (pix_out[c*PIX_W +: PIX_W] <= $past(pix_in[c*PIX_W +: PIX_W]))); // R4
  end
endmodule

bind black_level_corrector blc_chk #(.NCH(NCH), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_s(rst_n_s), .line_start(line_start), .dark_en(dark_en),
  .act_en(act_en), .pix_in(pix_in), .pix_out(pix_out), .out_valid(out_valid),
  .short_err(short_err), .black_bus(black_bus)
);

// File: tb/sim_black_level_corrector.sv
`timescale 1ns/1ps
module sim_black_level_corrector;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int W   = 12;

  logic clk = 1'b0;
  logic rst_n, line_start, dark_en, act_en;
  logic [NCH*W-1:0] pix_in;
  logic [NCH*W-1:0] pix_out;
  logic out_valid, short_err;

  int n_chk = 0;
  int n_bad = 0;
  int exp_blk [NCH];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  black_level_corrector u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .dark_en(dark_en),
    .act_en(act_en), .pix_in(pix_in), .pix_out(pix_out),
    .out_valid(out_valid), .short_err(short_err)
  );

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic drive(input bit ls, input bit dk, input bit ac,
                       input int v0, input int v1, input int v2);
    line_start = ls; dark_en = dk; act_en = ac;
    pix_in = {W'(v2), W'(v1), W'(v0)};
    @(negedge clk);
  endtask

  // One line: start pulse, idle, ndark shielded samples (after the 16th the
  // value is 4095), idle, nact active samples, idle tail.
  task automatic run_line(input string tag, input int ndark,
                          input int d0, input int d1, input int d2,
                          input int a0, input int a1, input int a2,
                          input int nact);
    int db [NCH];
    int ab [NCH];
    int sum [NCH];
    logic [NCH*W-1:0] held;
    db = '{d0, d1, d2};
    ab = '{a0, a1, a2};
    for (int c = 0; c < NCH; c++) sum[c] = 0;
    drive(1'b1, 1'b0, 1'b0, 0, 0, 0);
    chk({tag, " R8 err cleared after line_start"}, int'(short_err), 0);
    drive(1'b0, 1'b0, 1'b0, 4095, 4095, 4095);
    chk({tag, " R6 idle gives no valid"}, int'(out_valid), 0);
    for (int i = 0; i < ndark; i++) begin
      int v [NCH];
      for (int c = 0; c < NCH; c++) begin
        v[c] = (i < 16) ? db[c] + (i % 5) * 3 : 4095;
        if (i < 16) sum[c] += v[c];
      end
      drive(1'b0, 1'b1, 1'b0, v[0], v[1], v[2]);
    end
    if (ndark >= 16)
      for (int c = 0; c < NCH; c++) exp_blk[c] = sum[c] >> 4;  // R2, R7
    drive(1'b0, 1'b0, 1'b0, 4095, 4095, 4095);
    for (int j = 0; j < nact; j++) begin
      int v [NCH];
      for (int c = 0; c < NCH; c++) v[c] = (ab[c] + j * 3) % 4096;
      drive(1'b0, 1'b0, 1'b1, v[0], v[1], v[2]);
      chk({tag, " R3 valid"}, int'(out_valid), 1);
      chk({tag, " R8 short_err"}, int'(short_err), (ndark < 16) ? 1 : 0);
      for (int c = 0; c < NCH; c++) begin
        int e;
        e = (v[c] >= exp_blk[c]) ? v[c] - exp_blk[c] : 0;       // R4
        chk($sformatf("%s R5 ch%0d corrected", tag, c),
            int'(pix_out[c*W +: W]), e);
      end
    end
    held = pix_out;
    drive(1'b0, 1'b0, 1'b0, 7, 7, 7);
    chk({tag, " R6 tail valid low"}, int'(out_valid), 0);
    drive(1'b0, 1'b0, 1'b0, 9, 9, 9);
    chk({tag, " R6 tail pix_out held"}, int'(pix_out == held), 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 0, 0, 0);
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 err in reset", int'(short_err), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 1'b0, 0, 0, 0);
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 err after reset", int'(short_err), 0);
    for (int c = 0; c < NCH; c++) exp_blk[c] = 0;
  endtask

  initial begin
    rst_n = 1'b0; line_start = 1'b0; dark_en = 1'b0; act_en = 1'b0;
    pix_in = '0;
    @(negedge clk);
    t_reset();
    run_line("R10 no dark yet", 0, 0, 0, 0, 100, 200, 300, 4);
    run_line("R2 normal", 16, 40, 80, 120, 500, 1000, 1500, 6);
    run_line("R4 clamp", 16, 2000, 10, 4000, 1990, 5, 4090, 8);
    run_line("R7 extra dark", 20, 60, 70, 90, 300, 300, 300, 5);
    run_line("R8 short run", 10, 900, 900, 900, 700, 800, 900, 5);
    run_line("R9 recovered", 16, 0, 3, 4080, 50, 60, 4095, 4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule